// File: doc/BRIEF.md
# Event Timer Register Front End

This block is the register side of a multi-timer event timer. It holds a 64-bit main counter, a global configuration register, a read-only capability word and a read-only interrupt status view. It also holds three register groups per timer (configuration, comparator, route) and drives them out on ports, where the per-timer compare units pick them up. The block does no comparator matching and raises no interrupts.

A host reaches the registers through a 1 KB byte-addressed window. Each access is 1, 2, 4 or 8 bytes wide. A read returns the addressed bytes right-justified. A write changes only the addressed byte lanes, and then only the bits that the target register allows to be written. An access whose length is illegal, or whose address is not a multiple of its length, reads as all-ones and has no effect when written. The main counter counts while the global enable bit is set, freezes when it is cleared and carries on from the frozen value when it is set again.

Top module: `evt_regfile`

## Requirements
- R1: Registers sit at these byte offsets: capability 0x000, global config 0x010, status 0x020 (sts_i zero-extended), main counter 0x0F0. Timer n has its config at 0x100+0x20·n, its comparator at 0x108+0x20·n and its route at 0x110+0x20·n. Any other offset reads 0 and ignores writes.
- R2: An access is rejected when len_i is not 1, 2, 4 or 8, or when addr_i is not a multiple of len_i. A rejected read returns all-ones and a rejected write changes nothing.
- R3: A read of len_i bytes returns the 64-bit register shifted right by 8·addr_i[2:0], with every bit above the access width set to zero.
- R4: A write of len_i bytes replaces byte lanes addr_i[2:0] up to addr_i[2:0]+len_i-1 with the low bytes of wdata_i and keeps every other byte.
- R5: ready_o is high exactly one cycle after each cycle in which req_i is high. For a read, rdata_o holds the result in that same cycle.
- R6: Only bits [1:0] of the global config register can be written. Bit 0 is the counter enable (glb_en_o) and bit 1 is legacy routing (legacy_o). Both reset to 0.
- R7: A timer config write changes only the bits in mask 0x3F4E. All other bits keep their old value.
- R8: The capability register reads {PERIOD_FS, 0x8086A201} with the default NT=3. Bits 12:8 hold NT-1.
- R9: While enable is set, the main counter goes up by one every DIV (32) cycles. The first increment comes DIV cycles after the edge that sets enable. While enable is clear, the counter holds its value, and it resumes from that value when enable is set again.
- R10: A write to the main counter takes effect whether or not the counter is running. It takes priority over an increment at the same edge.
- R11: After reset, every comparator is all-ones, every route is 0 and every timer config reads 0x00F00000_00000030. That value means periodic-capable (bit 4), 64-bit-capable (bit 5), and a route-capability mask in bits 63:32 that allows lines 20..23 only.
- R12: A config write that leaves bit 8 (32-bit mode) set clears bits 63:32 of that timer's comparator. While bit 8 is set, a comparator write stores only its low 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | Byte address within the window |
| len_i | input | 4 | Access length in bytes |
| wdata_i | input | 64 | Write data, right-justified |
| sts_i | input | NT | Interrupt status from the timer units |
| ready_o | output | 1 | Access completion, one cycle after req_i |
| rdata_o | output | 64 | Read result, valid with ready_o |
| glb_en_o | output | 1 | Global enable |
| legacy_o | output | 1 | Legacy routing select |
| counter_o | output | 64 | Main counter value |
| tmr_cfg_o | output | 64·NT | Timer config registers, timer n at bits 64n+63:64n |
| tmr_cmp_o | output | 64·NT | Timer comparators |
| tmr_route_o | output | 64·NT | Timer route registers |

## Verification
The bench uses the default NT=3 and DIV=32, with PERIOD_FS set to a known value, so every field of the capability word can be predicted. NT=3 puts the last timer group at 0x140–0x150, which means one run covers all three groups and an unmapped gap above them. DIV=32 keeps each counter increment short enough that the bench can find the exact edge where the first increment lands, check the frozen value during a long halt, and check that counting resumes.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam logic [6:0] W_CAP  = 7'h00;  // word index = byte offset >> 3
  localparam logic [6:0] W_GCFG = 7'h02;
  localparam logic [6:0] W_STS  = 7'h04;
  localparam logic [6:0] W_CNT  = 7'h1E;
  localparam int unsigned TMR_BASE_W   = 32;  // 0x100 >> 3
  localparam int unsigned TMR_STRIDE_W = 4;   // 0x20 >> 3
  localparam logic [63:0] GCFG_WMASK = 64'h3;
  localparam logic [63:0] TCFG_WMASK = 64'h3F4E;
  localparam logic [63:0] TCFG_RST   = {32'h00F0_0000, 32'h0000_0030};
  localparam int unsigned TCFG_M32   = 8;
endpackage

// File: rtl/evt_acc_decode.sv
module evt_acc_decode (
  input  logic [9:0]  addr_i,
  input  logic [3:0]  len_i,
  output logic        ok_o,
  output logic [63:0] lane_o,
  output logic [5:0]  shift_o,
  output logic [6:0]  word_o
);
  logic       pow2;
  logic [8:0] bytes_run;
  logic [7:0] byte_en;

  always_comb begin
    pow2      = (len_i == 4'd1) || (len_i == 4'd2) || (len_i == 4'd4) || (len_i == 4'd8);
    ok_o      = pow2 && ((addr_i[2:0] & (len_i[2:0] - 3'd1)) == 3'd0);
    bytes_run = (9'd1 << len_i) - 9'd1;
    byte_en   = bytes_run[7:0] << addr_i[2:0];
    shift_o   = {addr_i[2:0], 3'b000};
    word_o    = addr_i[9:3];
  end

  for (genvar b = 0; b < 8; b++) begin : g_lane
    assign lane_o[8*b +: 8] = {8{byte_en[b]}};
  end
endmodule

// File: rtl/evt_main_counter.sv
module evt_main_counter #(
  parameter int unsigned W   = 64,
  parameter int unsigned DIV = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         wr_i,
  input  logic [W-1:0] wval_i,
  output logic [W-1:0] cnt_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;
  logic          tick;

  assign tick = en_i && (pre_q == PRE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (!en_i)     pre_q <= '0;
    else if (tick)      pre_q <= '0;
    else                pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_o <= '0;
    else if (wr_i)      cnt_o <= wval_i;  // write beats tick
    else if (tick)      cnt_o <= cnt_o + 1'b1;
  end

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_i) |=> $stable(cnt_o));
  a_r9_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wr_i) |=> ((cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 1'b1)));
  a_r10_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_o == $past(wval_i)));
endmodule

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic        cmp_we_i,
  input  logic        route_we_i,
  input  logic [63:0] wval_i,
  output logic [63:0] cfg_o,
  output logic [63:0] cmp_o,
  output logic [63:0] route_o
);
  logic [63:0] cfg_next;

  assign cfg_next = (wval_i & TCFG_WMASK) | (cfg_o & ~TCFG_WMASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o   <= TCFG_RST;
      cmp_o   <= '1;
      route_o <= '0;
    end else begin
      if (cfg_we_i) begin
        cfg_o <= cfg_next;
        if (cfg_next[TCFG_M32]) cmp_o <= {32'h0, cmp_o[31:0]};
      end
      if (cmp_we_i)
        cmp_o <= cfg_o[TCFG_M32] ? {32'h0, wval_i[31:0]} : wval_i;
      if (route_we_i)
        route_o <= wval_i;
    end
  end

  a_r7_fixed_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> ((cfg_o & ~TCFG_WMASK) == ($past(cfg_o) & ~TCFG_WMASK)));
  a_r12_narrow_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && wval_i[TCFG_M32]) |=> (cmp_o[63:32] == 32'h0));
  a_r12_narrow_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_we_i && cfg_o[TCFG_M32]) |=> (cmp_o[63:32] == 32'h0));
endmodule

// File: rtl/evt_regfile.sv
module evt_regfile
  import evt_pkg::*;
#(
  parameter int unsigned NT        = 3,
  parameter int unsigned DIV       = 32,
  parameter logic [31:0] PERIOD_FS = 32'h0429_B17F
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [9:0]       addr_i,
  input  logic [3:0]       len_i,
  input  logic [63:0]      wdata_i,
  input  logic [NT-1:0]    sts_i,
  output logic             ready_o,
  output logic [63:0]      rdata_o,
  output logic             glb_en_o,
  output logic             legacy_o,
  output logic [63:0]      counter_o,
  output logic [64*NT-1:0] tmr_cfg_o,
  output logic [64*NT-1:0] tmr_cmp_o,
  output logic [64*NT-1:0] tmr_route_o
);
  localparam logic [4:0]  NT_M1 = 5'(NT - 1);
  localparam logic [63:0] CAP_VAL = {PERIOD_FS, 16'h8086, 1'b1, 1'b0, 1'b1, NT_M1, 8'h01};

  logic        acc_ok;
  logic [63:0] lane;
  logic [5:0]  shift;
  logic [6:0]  word;
  logic [63:0] old_val, merged;
  logic        wr_ok, gcfg_hit;
  logic [1:0]  gcfg_q;
  logic [63:0] tcfg[NT], tcmp[NT], troute[NT];

  evt_acc_decode u_dec (
    .addr_i (addr_i), .len_i (len_i), .ok_o (acc_ok),
    .lane_o (lane), .shift_o (shift), .word_o (word)
  );

  always_comb begin
    old_val = '0;
    unique case (word)
      W_CAP:   old_val = CAP_VAL;
      W_GCFG:  old_val = {62'h0, gcfg_q};
      W_STS:   old_val = 64'(sts_i);
      W_CNT:   old_val = counter_o;
      default: old_val = '0;
    endcase
    for (int n = 0; n < NT; n++) begin
      if (word == 7'(TMR_BASE_W + TMR_STRIDE_W*n))     old_val = tcfg[n];
      if (word == 7'(TMR_BASE_W + TMR_STRIDE_W*n + 1)) old_val = tcmp[n];
      if (word == 7'(TMR_BASE_W + TMR_STRIDE_W*n + 2)) old_val = troute[n];
    end
  end

  assign merged   = ((wdata_i << shift) & lane) | (old_val & ~lane);
  assign wr_ok    = req_i && we_i && acc_ok;
  assign gcfg_hit = wr_ok && (word == W_GCFG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       gcfg_q <= '0;
    else if (gcfg_hit) gcfg_q <= merged[1:0] & GCFG_WMASK[1:0];
  end
  assign glb_en_o = gcfg_q[0];
  assign legacy_o = gcfg_q[1];

  evt_main_counter #(.W(64), .DIV(DIV)) u_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (gcfg_q[0]),
    .wr_i (wr_ok && (word == W_CNT)), .wval_i (merged), .cnt_o (counter_o)
  );

  for (genvar n = 0; n < NT; n++) begin : g_tmr
    localparam logic [6:0] WC = 7'(TMR_BASE_W + TMR_STRIDE_W*n);
    evt_timer_regs u_tmr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (wr_ok && (word == WC)),
      .cmp_we_i   (wr_ok && (word == WC + 7'd1)),
      .route_we_i (wr_ok && (word == WC + 7'd2)),
      .wval_i     (merged),
      .cfg_o      (tcfg[n]),
      .cmp_o      (tcmp[n]),
      .route_o    (troute[n])
    );
    assign tmr_cfg_o[64*n +: 64]   = tcfg[n];
    assign tmr_cmp_o[64*n +: 64]   = tcmp[n];
    assign tmr_route_o[64*n +: 64] = troute[n];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o <= 1'b0;
      rdata_o <= '0;
    end else begin
      ready_o <= req_i;
      if (req_i && !we_i)
        rdata_o <= acc_ok ? ((old_val >> shift) & (lane >> shift)) : '1;
      else if (req_i)
        rdata_o <= '0;
    end
  end

  a_r5_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ready_o);
  a_r5_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ready_o);
  a_r2_reject_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !acc_ok) |=> (rdata_o == '1));
  a_r6_gcfg_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gcfg_hit |=> ($stable(glb_en_o) && $stable(legacy_o)));
endmodule

// File: tb/evt_regfile_test.sv
`timescale 1ns/1ps
module evt_regfile_test;
  localparam logic [31:0] PF = 32'h0429_B17F;
  localparam int NV = 34;
  // {tag[3:0], we, addr[9:0], len[3:0], wdata[63:0], exp[63:0]}
  localparam logic [146:0] VEC [0:NV-1] = '{
    {4'd8,  1'b0, 10'h000, 4'd8, 64'h0, {PF, 32'h8086_A201}},       // R8
    {4'd3,  1'b0, 10'h004, 4'd4, 64'h0, {32'h0, PF}},               // R3
    {4'd3,  1'b0, 10'h001, 4'd1, 64'h0, 64'hA2},                    // R3
    {4'd3,  1'b0, 10'h002, 4'd2, 64'h0, 64'h8086},                  // R3
    {4'd2,  1'b0, 10'h003, 4'd2, 64'h0, {64{1'b1}}},                // R2
    {4'd2,  1'b0, 10'h000, 4'd3, 64'h0, {64{1'b1}}},                // R2
    {4'd11, 1'b0, 10'h100, 4'd8, 64'h0, 64'h00F0_0000_0000_0030},   // R11
    {4'd11, 1'b0, 10'h108, 4'd8, 64'h0, {64{1'b1}}},                // R11
    {4'd6,  1'b1, 10'h010, 4'd8, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0},
    {4'd6,  1'b0, 10'h010, 4'd8, 64'h0, 64'h2},                     // R6
    {4'd6,  1'b1, 10'h010, 4'd1, 64'h0, 64'h0},
    {4'd6,  1'b0, 10'h010, 4'd8, 64'h0, 64'h0},                     // R6
    {4'd7,  1'b1, 10'h100, 4'd8, {64{1'b1}}, 64'h0},
    {4'd7,  1'b0, 10'h100, 4'd8, 64'h0, 64'h00F0_0000_0000_3F7E},   // R7
    {4'd12, 1'b0, 10'h108, 4'd8, 64'h0, 64'h0000_0000_FFFF_FFFF},   // R12
    {4'd12, 1'b1, 10'h108, 4'd8, 64'h1234_5678_9ABC_DEF0, 64'h0},
    {4'd12, 1'b0, 10'h108, 4'd8, 64'h0, 64'h0000_0000_9ABC_DEF0},   // R12
    {4'd4,  1'b1, 10'h12C, 4'd4, 64'hDEAD_BEEF, 64'h0},
    {4'd4,  1'b0, 10'h128, 4'd8, 64'h0, 64'hDEAD_BEEF_FFFF_FFFF},   // R4
    {4'd4,  1'b1, 10'h14A, 4'd2, 64'h5AA5, 64'h0},
    {4'd4,  1'b0, 10'h148, 4'd8, 64'h0, 64'hFFFF_FFFF_5AA5_FFFF},   // R4
    {4'd1,  1'b1, 10'h150, 4'd8, 64'h0123_4567_89AB_CDEF, 64'h0},
    {4'd1,  1'b0, 10'h150, 4'd8, 64'h0, 64'h0123_4567_89AB_CDEF},   // R1
    {4'd2,  1'b1, 10'h131, 4'd2, 64'hFFFF, 64'h0},
    {4'd2,  1'b0, 10'h130, 4'd8, 64'h0, 64'h0},                     // R2
    {4'd1,  1'b1, 10'h200, 4'd8, 64'hFF, 64'h0},
    {4'd1,  1'b0, 10'h200, 4'd8, 64'h0, 64'h0},                     // R1
    {4'd1,  1'b0, 10'h018, 4'd8, 64'h0, 64'h0},                     // R1
    {4'd1,  1'b0, 10'h020, 4'd8, 64'h0, 64'h5},                     // R1
    {4'd10, 1'b1, 10'h0F0, 4'd8, 64'h100, 64'h0},
    {4'd10, 1'b0, 10'h0F0, 4'd8, 64'h0, 64'h100},                   // R10
    {4'd3,  1'b0, 10'h0F4, 4'd4, 64'h0, 64'h0},                     // R3
    {4'd3,  1'b0, 10'h0F1, 4'd1, 64'h0, 64'h01},                    // R3
    {4'd2,  1'b0, 10'h00C, 4'd8, 64'h0, {64{1'b1}}}                 // R2
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [9:0] addr = '0;
  logic [3:0] len = 4'd8;
  logic [63:0] wdata = '0;
  logic [2:0] sts = 3'b101;
  logic ready, glb_en, legacy;
  logic [63:0] rdata, counter;
  logic [191:0] tcfg, tcmp, troute;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evt_regfile #(.NT(3), .DIV(32), .PERIOD_FS(PF)) uut (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .we_i (we), .addr_i (addr),
    .len_i (len), .wdata_i (wdata), .sts_i (sts), .ready_o (ready),
    .rdata_o (rdata), .glb_en_o (glb_en), .legacy_o (legacy), .counter_o (counter),
    .tmr_cfg_o (tcfg), .tmr_cmp_o (tcmp), .tmr_route_o (troute)
  );

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [9:0] a, input logic [3:0] l,
                        input logic [63:0] d, output logic [63:0] r);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; len = l; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    check("R5 ready", 64'(ready), 64'h1);
    r = rdata;
  endtask

  initial begin
    logic [63:0] r;
    repeat (3) @(negedge clk);
    check("R6 reset enable", 64'(glb_en), 64'h0);
    check("R5 reset ready", 64'(ready), 64'h0);
    check("R9 reset counter", counter, 64'h0);
    check("R11 reset cmp2", tcmp[191:128], {64{1'b1}});
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 idle ready", 64'(ready), 64'h0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][142], VEC[i][141:132], VEC[i][131:128], VEC[i][127:64], r);
      if (!VEC[i][142]) check($sformatf("R%0d vector %0d", VEC[i][146:143], i), r, VEC[i][63:0]);
    end
    check("R12 cmp0 port", tcmp[63:0], 64'h0000_0000_9ABC_DEF0);
    check("R1 route2 port", troute[191:128], 64'h0123_4567_89AB_CDEF);

    // R6: legacy bit via one-byte write
    access(1'b1, 10'h010, 4'd1, 64'h2, r);
    check("R6 legacy", 64'({legacy, glb_en}), 64'h2);
    access(1'b1, 10'h010, 4'd1, 64'h0, r);

    // R9: counting, halting, resuming (counter holds 0x100)
    access(1'b1, 10'h010, 4'd1, 64'h1, r);
    repeat (31) @(negedge clk);
    check("R9 before first tick", counter, 64'h100);
    @(negedge clk);
    check("R9 first tick", counter, 64'h101);
    repeat (32) @(negedge clk);
    check("R9 second tick", counter, 64'h102);
    access(1'b1, 10'h010, 4'd1, 64'h0, r);
    check("R9 halt", counter, 64'h102);
    repeat (100) @(negedge clk);
    check("R9 held", counter, 64'h102);
    access(1'b1, 10'h010, 4'd1, 64'h1, r);
    repeat (32) @(negedge clk);
    check("R9 resume", counter, 64'h103);
    // R10: write while running
    access(1'b1, 10'h0F0, 4'd8, 64'h5000, r);
    check("R10 running write", counter, 64'h5000);
    access(1'b0, 10'h010, 4'd8, 64'h0, r);
    check("R6 enable readback", r, 64'h1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule